// File: doc/BRIEF.md
# Data Pointer Modify Unit

This unit holds the two address pointers of a small DSP datapath. The data-RAM pointer is 8 bits wide. The data-ROM pointer is 11 bits wide. Both pointers are updated once per instruction, on a cycle where the execute strobe is high. A move can write a new value into either pointer through a shared load bus. For instructions of the operation or return class, a post-step then changes the pointers.

The post-step has three parts:
- A 2-bit code acts on the low nibble of the data pointer: keep, increment, decrement or clear. Increment and decrement wrap inside the nibble, so the count never carries into the upper bits.
- A 4-bit mask is then XORed into the upper nibble of the data pointer.
- A single flag decrements the ROM pointer, which wraps modulo 2^11.

A load in the same instruction is applied first, so the post-step acts on the freshly loaded value. Two status outputs, taken from the registered data pointer, tell branch logic whether its low nibble is all zeros or all ones.

Top module: `ptr_modify_unit`

## Requirements
- R1: While rst_ni is low, dp_o and rp_o are 0, dp_lo_zero_o is 1 and dp_lo_full_o is 0.
- R2: A cycle with exec_i low changes neither pointer. A cycle with exec_i high, op_i low and no load also changes neither pointer.
- R3: With exec_i and op_i high, lo_code_i = 1 increments dp bits [3:0] modulo 16 without carry into bits [7:4].
- R4: With exec_i and op_i high, lo_code_i = 2 decrements dp bits [3:0] modulo 16 without borrow from bits [7:4].
- R5: With exec_i and op_i high, lo_code_i = 3 clears dp bits [3:0], and lo_code_i = 0 leaves them unchanged.
- R6: With exec_i and op_i high, dp bits [7:4] become their previous value XOR hi_mask_i. This is applied after the low-nibble step.
- R7: With exec_i, op_i and rp_dec_i high, rp decreases by one modulo 2048.
- R8: When dp_ld_i or rp_ld_i is high with exec_i, the pointer first takes ld_data_i (dp takes bits [7:0], rp takes bits [10:0]). Any post-step in the same cycle then applies to that loaded value.
- R9: With op_i low, a load writes ld_data_i unmodified. lo_code_i, hi_mask_i and rp_dec_i have no effect.
- R10: dp_lo_zero_o is 1 exactly when dp_o[3:0] is 0x0. dp_lo_full_o is 1 exactly when dp_o[3:0] is 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Instruction execute strobe |
| op_i | input | 1 | Instruction is operation or return class (enables post-step) |
| lo_code_i | input | 2 | Low-nibble step: 0 keep, 1 inc, 2 dec, 3 clear |
| hi_mask_i | input | 4 | XOR mask for dp bits [7:4] |
| rp_dec_i | input | 1 | Decrement rp after the operation |
| dp_ld_i | input | 1 | Load dp from ld_data_i |
| rp_ld_i | input | 1 | Load rp from ld_data_i |
| ld_data_i | input | 11 | Move-destination load data |
| dp_o | output | 8 | Data-RAM pointer |
| rp_o | output | 11 | Data-ROM pointer |
| dp_lo_zero_o | output | 1 | dp_o[3:0] == 0x0 |
| dp_lo_full_o | output | 1 | dp_o[3:0] == 0xF |

## Verification
The hardest case to reach is a load and a post-step in the same instruction. The result shows whether the load took effect first, but only if the loaded value differs from the held one in both nibbles. It must also sit where a wrong ordering gives a different answer. The stimulus therefore loads dp with 0xA5 while asking for a decrement and a mask of 0x5, which must give 0xF4. It also loads rp with 0 under a decrement, which must wrap to 0x7FF. The nibble wraps 0xF to 0x0 and 0x0 to 0xF are reached by chained steps from a loaded value.

// File: rtl/ptr_mod_pkg.sv
package ptr_mod_pkg;
  typedef enum logic [1:0] {
    LO_KEEP = 2'd0,
    LO_INC  = 2'd1,
    LO_DEC  = 2'd2,
    LO_CLR  = 2'd3
  } lo_op_e;
endpackage

// File: rtl/dp_low_step.sv
module dp_low_step
  import ptr_mod_pkg::*;
#(
  parameter int LO_W = 4
) (
  input  lo_op_e            op_i,
  input  logic [LO_W-1:0]   nib_i,
  output logic [LO_W-1:0]   nib_o
);
  always_comb begin
    unique case (op_i)
      LO_INC:  nib_o = nib_i + 1'b1;
      LO_DEC:  nib_o = nib_i - 1'b1;
      LO_CLR:  nib_o = '0;
      default: nib_o = nib_i;
    endcase
  end
endmodule

// File: rtl/dp_next.sv
module dp_next
  import ptr_mod_pkg::*;
#(
  parameter int DP_W = 8,
  parameter int LO_W = 4,
  localparam int HI_W = DP_W - LO_W
) (
  input  logic [DP_W-1:0] base_i,
  input  logic            mod_en_i,
  input  lo_op_e          lo_op_i,
  input  logic [HI_W-1:0] hi_mask_i,
  output logic [DP_W-1:0] next_o
);
  logic [LO_W-1:0] lo_step;

  dp_low_step #(.LO_W(LO_W)) u_lo (
    .op_i  (lo_op_i),
    .nib_i (base_i[LO_W-1:0]),
    .nib_o (lo_step)
  );

  always_comb begin
    if (mod_en_i) next_o = {base_i[DP_W-1:LO_W] ^ hi_mask_i, lo_step};
    else          next_o = base_i;
  end
endmodule

// File: rtl/rp_next.sv
module rp_next #(
  parameter int RP_W = 11
) (
  input  logic [RP_W-1:0] base_i,
  input  logic            dec_i,
  output logic [RP_W-1:0] next_o
);
  assign next_o = dec_i ? base_i - 1'b1 : base_i;
endmodule

// File: rtl/ptr_modify_unit.sv
module ptr_modify_unit
  import ptr_mod_pkg::*;
#(
  parameter int DP_W = 8,
  parameter int RP_W = 11,
  parameter int LO_W = 4,
  localparam int HI_W = DP_W - LO_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exec_i,
  input  logic            op_i,
  input  logic [1:0]      lo_code_i,
  input  logic [HI_W-1:0] hi_mask_i,
  input  logic            rp_dec_i,
  input  logic            dp_ld_i,
  input  logic            rp_ld_i,
  input  logic [RP_W-1:0] ld_data_i,
  output logic [DP_W-1:0] dp_o,
  output logic [RP_W-1:0] rp_o,
  output logic            dp_lo_zero_o,
  output logic            dp_lo_full_o
);
  logic [DP_W-1:0] dp_q, dp_base, dp_d;
  logic [RP_W-1:0] rp_q, rp_base, rp_d;

  // load precedes modification
  assign dp_base = dp_ld_i ? ld_data_i[DP_W-1:0] : dp_q;
  assign rp_base = rp_ld_i ? ld_data_i : rp_q;

  dp_next #(.DP_W(DP_W), .LO_W(LO_W)) u_dp (
    .base_i    (dp_base),
    .mod_en_i  (op_i),
    .lo_op_i   (lo_op_e'(lo_code_i)),
    .hi_mask_i (hi_mask_i),
    .next_o    (dp_d)
  );

  rp_next #(.RP_W(RP_W)) u_rp (
    .base_i (rp_base),
    .dec_i  (op_i & rp_dec_i),
    .next_o (rp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_q <= '0;
      rp_q <= '0;
    end else if (exec_i) begin
      dp_q <= dp_d;
      rp_q <= rp_d;
    end
  end

  assign dp_o         = dp_q;
  assign rp_o         = rp_q;
  assign dp_lo_zero_o = (dp_q[LO_W-1:0] == '0);
  assign dp_lo_full_o = &dp_q[LO_W-1:0];
endmodule

// File: rtl/ptr_modify_chk.sv
module ptr_modify_chk #(
  parameter int DP_W = 8,
  parameter int RP_W = 11,
  parameter int LO_W = 4,
  localparam int HI_W = DP_W - LO_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exec_i,
  input logic            op_i,
  input logic [1:0]      lo_code_i,
  input logic [HI_W-1:0] hi_mask_i,
  input logic            rp_dec_i,
  input logic            dp_ld_i,
  input logic            rp_ld_i,
  input logic [RP_W-1:0] ld_data_i,
  input logic [DP_W-1:0] dp_o,
  input logic [RP_W-1:0] rp_o,
  input logic            dp_lo_zero_o,
  input logic            dp_lo_full_o
);
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> ($stable(dp_o) && $stable(rp_o))); // R2

  AST_LO_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i && !dp_ld_i && lo_code_i == 2'd1)
      |=> dp_o[LO_W-1:0] == LO_W'($past(dp_o[LO_W-1:0]) + 1'b1)); // R3

  AST_LO_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i && !dp_ld_i && lo_code_i == 2'd2)
      |=> dp_o[LO_W-1:0] == LO_W'($past(dp_o[LO_W-1:0]) - 1'b1)); // R4

  AST_HI_XOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i && !dp_ld_i)
      |=> dp_o[DP_W-1:LO_W] == ($past(dp_o[DP_W-1:LO_W]) ^ $past(hi_mask_i))); // R6

  AST_RP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i && rp_dec_i && !rp_ld_i)
      |=> rp_o == RP_W'($past(rp_o) - 1'b1)); // R7

  AST_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i && dp_ld_i && lo_code_i == 2'd3)
      |=> dp_o == {$past(ld_data_i[DP_W-1:LO_W]) ^ $past(hi_mask_i), {LO_W{1'b0}}}); // R8

  AST_LOAD_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !op_i && dp_ld_i) |=> dp_o == $past(ld_data_i[DP_W-1:0])); // R9

  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dp_lo_zero_o, dp_lo_full_o})); // R10
endmodule

bind ptr_modify_unit ptr_modify_chk #(.DP_W(DP_W), .RP_W(RP_W), .LO_W(LO_W)) u_chk (.*);

// File: tb/sim_ptr_modify_unit.sv
module sim_ptr_modify_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ex, op, rd, dl, rl;
  logic [1:0] lo;
  logic [3:0] hi;
  logic [10:0] d;
  logic [7:0] dp;
  logic [10:0] rp;
  logic zf, ff;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ptr_modify_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(ex), .op_i(op), .lo_code_i(lo),
    .hi_mask_i(hi), .rp_dec_i(rd), .dp_ld_i(dl), .rp_ld_i(rl), .ld_data_i(d),
    .dp_o(dp), .rp_o(rp), .dp_lo_zero_o(zf), .dp_lo_full_o(ff)
  );

  typedef struct packed {
    logic ex; logic op; logic [1:0] lo; logic [3:0] hi; logic rd;
    logic dl; logic rl; logic [10:0] d; logic [7:0] edp; logic [10:0] erp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,2'd1,4'hF,1'b1,1'b1,1'b1,11'h03E,8'h3E,11'h03E,4'd9}, // R9 load raw
    '{1'b1,1'b1,2'd1,4'h0,1'b0,1'b0,1'b0,11'h000,8'h3F,11'h03E,4'd3}, // R3
    '{1'b1,1'b1,2'd1,4'h0,1'b0,1'b0,1'b0,11'h000,8'h30,11'h03E,4'd3}, // R3 wrap
    '{1'b1,1'b1,2'd2,4'h0,1'b0,1'b0,1'b0,11'h000,8'h3F,11'h03E,4'd4}, // R4 wrap
    '{1'b1,1'b1,2'd3,4'h0,1'b0,1'b0,1'b0,11'h000,8'h30,11'h03E,4'd5}, // R5 clear
    '{1'b1,1'b1,2'd0,4'h0,1'b1,1'b0,1'b0,11'h000,8'h30,11'h03D,4'd7}, // R7, R5 keep
    '{1'b1,1'b1,2'd1,4'hA,1'b0,1'b0,1'b0,11'h000,8'h91,11'h03D,4'd6}, // R6
    '{1'b0,1'b1,2'd3,4'hF,1'b1,1'b1,1'b1,11'h7FF,8'h91,11'h03D,4'd2}, // R2 no exec
    '{1'b1,1'b1,2'd0,4'h0,1'b1,1'b0,1'b1,11'h000,8'h91,11'h7FF,4'd8}, // R8 rp
    '{1'b1,1'b1,2'd2,4'h5,1'b0,1'b1,1'b0,11'h0A5,8'hF4,11'h7FF,4'd8}, // R8 dp
    '{1'b1,1'b0,2'd1,4'hF,1'b1,1'b0,1'b0,11'h123,8'hF4,11'h7FF,4'd2}, // R2 no op
    '{1'b1,1'b1,2'd1,4'h0,1'b0,1'b0,1'b0,11'h000,8'hF5,11'h7FF,4'd3}  // R3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag, input logic [7:0] edp);
    chk({tag, " R10 zero"}, 32'(zf), 32'(edp[3:0] == 4'h0));
    chk({tag, " R10 full"}, 32'(ff), 32'(edp[3:0] == 4'hF));
  endtask

  task automatic idle();
    ex = 0; op = 0; lo = 0; hi = 0; rd = 0; dl = 0; rl = 0; d = '0;
  endtask

  initial begin
    idle();
    #12;
    chk("R1 dp", 32'(dp), 0);
    chk("R1 rp", 32'(rp), 0);
    chk_flags("R1", 8'h00);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      ex = VECS[i].ex; op = VECS[i].op; lo = VECS[i].lo; hi = VECS[i].hi;
      rd = VECS[i].rd; dl = VECS[i].dl; rl = VECS[i].rl; d = VECS[i].d;
      @(negedge clk);
      chk($sformatf("R%0d dp vec%0d", VECS[i].req, i), 32'(dp), 32'(VECS[i].edp));
      chk($sformatf("R%0d rp vec%0d", VECS[i].req, i), 32'(rp), 32'(VECS[i].erp));
      chk_flags($sformatf("vec%0d", i), VECS[i].edp);
    end
    // R8: clear after load, with mask
    ex = 1; op = 1; lo = 2'd3; hi = 4'h6; dl = 1; rl = 0; rd = 0; d = 11'h02F;
    @(negedge clk);
    chk("R8 load then clear", 32'(dp), 32'h40);
    chk_flags("R8", 8'h40);
    // R1: asynchronous reset mid-run
    idle();
    rst_n = 1'b0; #1;
    chk("R1 async dp", 32'(dp), 0);
    chk("R1 async rp", 32'(rp), 0);
    chk_flags("R1 async", 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule